// File: doc/BRIEF.md
# Two-Line Edge-Triggered Interrupt Source Bank

This block collects up to a few dozen external interrupt sources and presents them to two independent host interrupt lines. Each source passes through a two-flop synchronizer. A 2-bit trigger field chooses rising, falling, both or no edges. A detected edge sets a status bit in both lines at once. Each line has its own status and mask bytes and its own active-low summary output. The trigger fields are shared between the two lines.

A host reaches the block through a byte-wide register port: address, write data, write strobe, read strobe and combinational read data. Two bits in a control byte choose the clearing style and the buffering style:

- Clear-on-read: reading a status byte clears the bits that read returned.
- Write-one-to-clear: writing a 1 to a status bit clears it.
- Second-event buffering: an edge that arrives while the status bit is already set is held, and the bit comes back after it is cleared.

Top module: `irq_bank`

## Requirements
- R1: After reset, both summary outputs are high (inactive), and the control, trigger and status bytes read 0. Every mask bit of each line reads 1, and each mask byte reads 0xFF when the source count is a multiple of 8.
- R2: Source i owns the trigger bits at byte i/4 of the trigger array, bit offsets 2*(i mod 4)+1 and 2*(i mod 4). The upper bit enables rising-edge detection and the lower bit enables falling-edge detection.
- R3: A source whose two trigger bits are both 0 never sets a status bit on either line.
- R4: An input change that is held stable is seen as an edge after the two-flop synchronizer. The edge sets the source's status bit on both lines at the third rising clock edge after the change.
- R5: Line L's summary output `irq_n[L]` is low exactly when some status bit of line L is 1 and the matching mask bit of line L is 0. A mask bit of 1 blocks its source.
- R6: With control bit 0 set (clear-on-read), a read of a status byte returns that byte and then clears the returned bits. Writes to status bytes have no effect in this mode.
- R7: With control bit 0 clear (write-one-to-clear), writing a status byte clears the bits written as 1, and reading a status byte does not change it.
- R8: Clearing a status bit on one line leaves the same bit on the other line unchanged.
- R9: With control bit 1 set, an edge that arrives while the status bit is 1 is buffered. When that bit is then cleared, it reads as 1 again in the next cycle. With control bit 1 clear, no second edge is kept.
- R10: The byte addresses are laid out as follows, where S = ceil(N/8) and T = ceil(2N/8). Unmapped addresses read 0.

  | Region | Start | Length |
  |---|---|---|
  | Control | 0 | 1 |
  | Trigger array | 1 | T |
  | Line-0 status | 1+T | S |
  | Line-0 mask | 1+T+S | S |
  | Line-1 status | 1+T+2S | S |
  | Line-1 mask | 1+T+3S | S |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | N_SRC | Raw interrupt source inputs |
| addr | input | AW | Register byte address |
| wdata | input | 8 | Register write data |
| wr | input | 1 | Write strobe, one byte per cycle |
| rd | input | 1 | Read strobe, one byte per cycle |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq_n | output | 2 | Active-low summary interrupt, one per line |

## Verification
A source change driven between clock edges sets status at the third following rising edge. A register write or clearing read takes effect at the next rising edge. Read data, and `irq_n` derived from the current status and mask, are valid in the same cycle as the strobe. The bench keeps a behavioural model that delays the sampled inputs through a queue and applies the same edge-by-edge rules. It drives inputs on the falling edge and compares `irq_n`, and `rdata` on every read, just after that. The model is then advanced on the rising edge, so each expected value is compared in exactly the cycle in which it is due.

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int N_SRC = 24,
  parameter int AW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_in,
  input  logic [AW-1:0]    addr,
  input  logic [7:0]       wdata,
  input  logic             wr,
  input  logic             rd,
  output logic [7:0]       rdata,
  output logic [1:0]       irq_n
);
  localparam int SB  = (N_SRC + 7) / 8;
  localparam int TB  = (2 * N_SRC + 7) / 8;
  localparam int SW  = SB * 8;
  localparam int TRB = 1;
  localparam int ST0 = TRB + TB;
  localparam int MK0 = ST0 + SB;
  localparam int ST1 = MK0 + SB;
  localparam int MK1 = ST1 + SB;
  localparam logic [SW-1:0] VALID = SW'((SW+1)'(1) << N_SRC) - SW'(1);

  logic [1:0]         ctrl;
  logic [TB*8-1:0]    trig;
  logic [N_SRC-1:0]   s1, s2, s3;
  logic [SW-1:0]      ev;
  logic [1:0][SW-1:0] st, pd, mk, clr, st_nx, pd_nx;

  wire cor    = ctrl[0];
  wire buf_en = ctrl[1];
  wire [31:0] a = 32'(addr);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s3} <= '0;
    else begin
      s1 <= src_in;
      s2 <= s1;
      s3 <= s2;
    end

  always_comb begin
    ev = '0;
    for (int i = 0; i < N_SRC; i++)
      ev[i] = (s2[i] & ~s3[i] & trig[2*i+1]) | (~s2[i] & s3[i] & trig[2*i]);
  end

  always_comb begin
    for (int l = 0; l < 2; l++) begin
      clr[l] = '0;
      for (int b = 0; b < SB; b++)
        if (a == (l == 0 ? ST0 : ST1) + b) begin
          if (rd && cor)  clr[l][b*8 +: 8] = st[l][b*8 +: 8];
          if (wr && !cor) clr[l][b*8 +: 8] = wdata;
        end
      st_nx[l] = (ev | (st[l] & ~clr[l]) | (pd[l] & clr[l])) & VALID;
      pd_nx[l] = {SW{buf_en}} & VALID &
                 ((pd[l] & ~clr[l]) | (ev & st[l] & ~clr[l]) | (ev & pd[l] & clr[l]));
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl <= '0;
      trig <= '0;
      st   <= '0;
      pd   <= '0;
      mk   <= {VALID, VALID};
    end else begin
      st <= st_nx;
      pd <= pd_nx;
      if (wr && a == 0) ctrl <= wdata[1:0];
      for (int b = 0; b < TB; b++)
        if (wr && a == TRB + b) trig[b*8 +: 8] <= wdata;
      for (int l = 0; l < 2; l++)
        for (int b = 0; b < SB; b++)
          if (wr && a == (l == 0 ? MK0 : MK1) + b)
            mk[l][b*8 +: 8] <= wdata & VALID[b*8 +: 8];
    end

  always_comb begin
    rdata = '0;
    if (a == 0) rdata = {6'b0, ctrl};
    for (int b = 0; b < TB; b++)
      if (a == TRB + b) rdata = trig[b*8 +: 8];
    for (int b = 0; b < SB; b++) begin
      if (a == ST0 + b) rdata = st[0][b*8 +: 8];
      if (a == MK0 + b) rdata = mk[0][b*8 +: 8];
      if (a == ST1 + b) rdata = st[1][b*8 +: 8];
      if (a == MK1 + b) rdata = mk[1][b*8 +: 8];
    end
  end

  assign irq_n[0] = ~|(st[0] & ~mk[0]);
  assign irq_n[1] = ~|(st[1] & ~mk[1]);

  logic [SW-1:0] off;
  always_comb begin
    off = '0;
    for (int i = 0; i < N_SRC; i++) off[i] = ~trig[2*i+1] & ~trig[2*i];
  end

  AST_OFF_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ((st[0] | st[1]) & ~$past(st[0] | st[1]) & ~$past(pd[0] | pd[1]) & $past(off)) == '0); // R3
  AST_EDGE_BOTH_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    ((st[0] & st[1] & $past(ev)) == $past(ev))); // R4
  AST_FULL_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((mk[0] & VALID) == VALID) |-> irq_n[0]); // R5
  AST_READ_KEEPS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd && !wr && !cor) |-> ((st[0] & $past(st[0])) == $past(st[0]))); // R7
  AST_NO_BUF_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!buf_en) && !buf_en) |-> (pd[1] == '0)); // R9
endmodule

// File: tb/test_irq_bank.sv
module test_irq_bank;
  localparam int N = 24;
  localparam int AW = 5;
  localparam int CLK_PERIOD = 10;
  localparam int SB = (N + 7) / 8;
  localparam int TB = (2 * N + 7) / 8;
  localparam int A_TRIG = 1;
  localparam int A_ST0 = A_TRIG + TB;
  localparam int A_MK0 = A_ST0 + SB;
  localparam int A_ST1 = A_MK0 + SB;
  localparam int A_MK1 = A_ST1 + SB;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] src_in = '0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic wr = 0, rd = 0;
  logic [1:0] irq_n;
  int vectors = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_bank #(.N_SRC(N), .AW(AW)) i_irq_bank (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .addr(addr), .wdata(wdata),
    .wr(wr), .rd(rd), .rdata(rdata), .irq_n(irq_n));

  int m_ctrl = 0;
  bit m_trig [2*N];
  bit m_st [2][N];
  bit m_pd [2][N];
  bit m_mk [2][N];
  logic [N-1:0] hist [$];

  function automatic int st_base(int l); return l == 0 ? A_ST0 : A_ST1; endfunction
  function automatic int mk_base(int l); return l == 0 ? A_MK0 : A_MK1; endfunction

  function automatic logic [7:0] m_read(int ad);
    logic [7:0] v = 0;
    if (ad == 0) v = 8'(m_ctrl);
    for (int k = 0; k < 8; k++) begin
      if (ad >= A_TRIG && ad < A_TRIG + TB && (ad-A_TRIG)*8+k < 2*N)
        v[k] = m_trig[(ad-A_TRIG)*8+k];
      for (int l = 0; l < 2; l++) begin
        if (ad >= st_base(l) && ad < st_base(l)+SB && (ad-st_base(l))*8+k < N)
          v[k] = m_st[l][(ad-st_base(l))*8+k];
        if (ad >= mk_base(l) && ad < mk_base(l)+SB && (ad-mk_base(l))*8+k < N)
          v[k] = m_mk[l][(ad-mk_base(l))*8+k];
      end
    end
    return v;
  endfunction

  function automatic logic m_irq(int l);
    for (int i = 0; i < N; i++) if (m_st[l][i] && !m_mk[l][i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic model_edge();
    bit e [N];
    bit c;
    int ad = int'(addr);
    for (int i = 0; i < N; i++) begin
      bit nw = hist[1][i], od = hist[2][i];
      e[i] = (nw && !od && m_trig[2*i+1]) || (!nw && od && m_trig[2*i]);
    end
    for (int l = 0; l < 2; l++)
      for (int i = 0; i < N; i++) begin
        bit s = m_st[l][i], p = m_pd[l][i];
        c = 0;
        if (ad == st_base(l) + i/8) begin
          if (rd && m_ctrl[0]) c = s;
          if (wr && !m_ctrl[0]) c = wdata[i%8];
        end
        if (c) begin
          m_st[l][i] = e[i] || p;
          m_pd[l][i] = m_ctrl[1] && p && e[i];
        end else begin
          m_st[l][i] = e[i] || s;
          m_pd[l][i] = m_ctrl[1] && (p || (e[i] && s));
        end
      end
    if (wr) begin
      if (ad == 0) m_ctrl = int'(wdata[1:0]);
      for (int k = 0; k < 8; k++) begin
        if (ad >= A_TRIG && ad < A_TRIG+TB) m_trig[(ad-A_TRIG)*8+k] = wdata[k];
        for (int l = 0; l < 2; l++)
          if (ad >= mk_base(l) && ad < mk_base(l)+SB && (ad-mk_base(l))*8+k < N)
            m_mk[l][(ad-mk_base(l))*8+k] = wdata[k];
      end
    end
    hist.push_front(src_in);
    hist = hist[0:2];
  endtask

  task automatic cyc(input string tag);
    #1;
    for (int l = 0; l < 2; l++) begin
      vectors++;
      if (irq_n[l] !== m_irq(l)) begin
        errors++;
        $display("FAIL %s irq_n[%0d] got %b exp %b", tag, l, irq_n[l], m_irq(l));
      end
    end
    if (rd) begin
      vectors++;
      if (rdata !== m_read(int'(addr))) begin
        errors++;
        $display("FAIL %s rdata@%0d got %h exp %h", tag, addr, rdata, m_read(int'(addr)));
      end
    end
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle(int n, input string tag);
    for (int k = 0; k < n; k++) cyc(tag);
  endtask

  task automatic rd_reg(int ad, input string tag);
    addr = AW'(ad); rd = 1; cyc(tag); rd = 0;
  endtask

  task automatic wr_reg(int ad, logic [7:0] d, input string tag);
    addr = AW'(ad); wdata = d; wr = 1; cyc(tag); wr = 0;
  endtask

  initial begin
    for (int l = 0; l < 2; l++) for (int i = 0; i < N; i++) m_mk[l][i] = 1;
    hist = '{'0, '0, '0};
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 R10: reset values and full address map
    for (int ad = 0; ad < 32; ad++) rd_reg(ad, "R1_R10 reset map");
    // R2: trigger placement
    wr_reg(A_TRIG + 0, 8'h06, "R2 trig src0 rise src1 fall");
    wr_reg(A_TRIG + 1, 8'h0C, "R2 trig src5 both");
    wr_reg(A_TRIG + 2, 8'h08, "R2 trig src9 rise");
    for (int ad = A_TRIG; ad < A_TRIG + 4; ad++) rd_reg(ad, "R2 trig readback");
    wr_reg(A_MK0, 8'h00, "R5 unmask line0");
    wr_reg(A_MK0 + 1, 8'h00, "R5 unmask line0");
    wr_reg(A_MK1, 8'hFE, "R5 unmask src0 line1");
    // R4: rising edge on src0 plus untriggered src20 (R3)
    src_in[0] = 1; src_in[20] = 1;
    idle(5, "R4 sync latency");
    rd_reg(A_ST0, "R4 line0 status");
    rd_reg(A_ST1, "R4 line1 status");
    rd_reg(A_ST0 + 2, "R3 src20 off");
    src_in[1] = 1; idle(4, "R2 src1 rise ignored");
    rd_reg(A_ST0, "R2 rise on fall-only");
    src_in[1] = 0; src_in[5] = 1; idle(5, "R2 fall and both");
    src_in[5] = 0; src_in[9] = 1; src_in[20] = 0; idle(5, "R2 src5 fall src9 rise");
    rd_reg(A_ST0, "R2 status byte0");
    rd_reg(A_ST0 + 1, "R2 status byte1");
    rd_reg(A_ST0 + 2, "R3 status byte2");
    // R7 R8: write-one-to-clear mode
    rd_reg(A_ST0, "R7 read keeps");
    wr_reg(A_ST0, 8'h01, "R8 clear src0 line0");
    rd_reg(A_ST0, "R8 line0 cleared");
    rd_reg(A_ST1, "R8 line1 kept");
    wr_reg(A_ST0, 8'hFF, "R7 clear byte0");
    wr_reg(A_ST0 + 1, 8'hFF, "R7 clear byte1");
    idle(2, "R5 line0 idle");
    // R6: clear-on-read
    wr_reg(0, 8'h01, "R6 enable clear-on-read");
    rd_reg(0, "R6 ctrl readback");
    wr_reg(A_ST1, 8'hFF, "R6 write ignored");
    rd_reg(A_ST1, "R6 read returns");
    rd_reg(A_ST1, "R6 read cleared");
    rd_reg(A_ST1 + 1, "R6 clear line1 byte1");
    rd_reg(A_ST1 + 1, "R6 byte1 cleared");
    // R9: second-pending buffer
    wr_reg(0, 8'h03, "R9 enable buffering");
    src_in[0] = 0; idle(4, "R9 fall no trigger");
    src_in[0] = 1; idle(4, "R9 first rise");
    src_in[0] = 0; idle(4, "R9 gap");
    src_in[0] = 1; idle(4, "R9 second rise");
    rd_reg(A_ST0, "R9 read first");
    rd_reg(A_ST0, "R9 reasserted");
    rd_reg(A_ST0, "R9 finally cleared");
    wr_reg(0, 8'h01, "R9 buffering off");
    src_in[0] = 0; idle(4, "R9 gap");
    src_in[0] = 1; idle(4, "R9 rise a");
    src_in[0] = 0; idle(4, "R9 gap");
    src_in[0] = 1; idle(4, "R9 rise b");
    rd_reg(A_ST0, "R9 single");
    rd_reg(A_ST0, "R9 no reassert");
    // R5: mask blocks, then unmask shows pending
    wr_reg(A_MK1, 8'hFF, "R5 mask line1");
    src_in[9] = 0; src_in[9] = 0;
    src_in[0] = 0; idle(4, "R5");
    src_in[0] = 1; idle(5, "R5 masked line1 pending");
    wr_reg(A_MK1, 8'h00, "R5 unmask line1");
    idle(2, "R5 line1 active");
    rd_reg(A_MK1, "R5 mask readback");
    rd_reg(A_ST1, "R5 line1 status");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired got hang exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule